// File: doc/BRIEF.md
# Asynchronous static RAM access controller

This block connects a clocked host to an external asynchronous static RAM of 128K bytes. The host raises a request together with a 17-bit address, a direction flag and, for writes, a data byte. It holds the request until the one-cycle acknowledge arrives. For reads, the byte is returned in a register that is valid alongside that acknowledge.

On the memory side the controller drives the address, two chip selects of opposite polarity (low-true and high-true), a low-true output enable and a low-true write strobe. It also drives the outgoing data byte and an enable for the data pad drivers, and it reads the incoming data byte. The RAM has no clock. Every timing figure is therefore met by holding each phase for a whole number of clock cycles. The counts are derived at elaboration time by rounding the nanosecond parameters up against the clock period.

When no transaction is running, the RAM is held in standby: the low-true select is high and the high-true select is low. A write never lowers the output enable, and the controller drives the data pads only while the write strobe is low plus one hold cycle. As a result, the controller and the RAM never drive the bus at the same time.

Top module: `asram_ctrl`

## Requirements
- R1: Out of reset and whenever no transaction is in progress, mem_ce_n is 1 and mem_ce is 0, mem_oe_n and mem_we_n are 1, mem_dq_oe and ack are 0; rsp_rdata resets to 0.
- R2: A read keeps the chip selected with mem_oe_n high for one setup cycle, then holds mem_oe_n low for exactly RD_CYC = ceil(T_AA_NS/CLK_NS) cycles while mem_we_n stays high.
- R3: A read accepted in idle raises ack exactly RD_CYC+2 clock edges after the accepting edge is counted as the first. rsp_rdata then holds the byte stored at the requested address, and ack is high for one cycle only.
- R4: A write holds mem_we_n low for exactly WP_CYC = ceil(max(T_WP_NS,T_DW_NS)/CLK_NS) cycles with mem_oe_n high. mem_dq_oe is 1 and mem_dq_out carries the request byte whenever mem_we_n is low, including the edge where mem_we_n rises.
- R5: mem_addr does not change during any run of consecutive cycles in which the chip is selected.
- R6: A write accepted in idle raises ack exactly WP_CYC+3 clock edges after the accepting edge is counted as the first.
- R7: After mem_oe_n rises at the end of a read, the chip stays deselected for at least TURN_CYC = ceil(T_HZ_NS/CLK_NS) cycles, plus the idle accept cycle, before it is selected again.
- R8: mem_dq_oe is never 1 while mem_oe_n is 0.
- R9: Request address, data and direction are sampled only on the accepting edge; changing them while the transaction runs has no effect on the cycle performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Transaction request, held until ack |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_rdata | output | 8 | Read byte register |
| ack | output | 1 | One-cycle completion pulse |
| mem_addr | output | 17 | RAM address |
| mem_ce_n | output | 1 | Low-true chip select |
| mem_ce | output | 1 | High-true chip select |
| mem_oe_n | output | 1 | Low-true output enable |
| mem_we_n | output | 1 | Low-true write strobe |
| mem_dq_out | output | 8 | Byte to data pads |
| mem_dq_oe | output | 1 | Pad driver enable |
| mem_dq_in | input | 8 | Byte from data pads |

## Verification
The bench instantiates the block with slow-grade timings: RD_CYC=3, WP_CYC=2 and TURN_CYC=2. Under these settings, ack for a read starts from an idle state is due on the fifth edge counted from the accepting edge, and ack for such a write is also due on the fifth edge. The bench counts those edges and checks the exact count only when it has waited out an idle gap first. Strobe widths, address stability and the deselect gap are measured on falling edges, half a cycle after the registers switch. Read data is taken in the same half-cycle in which ack is seen.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_HOLD  = 3'd4,
    ST_TURN  = 3'd5
  } asram_state_e;

  // Round a nanosecond figure up to whole clock cycles, never below one.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_wait_cnt.sv
`timescale 1ns/1ps
// Down counter that times one phase of a RAM cycle.
module asram_wait_cnt #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/asram_dpath.sv
`timescale 1ns/1ps
// Request capture and read-data register.
module asram_dpath #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic              in_wr,
  input  logic [DATA_W-1:0] pad_din,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              wr_q,
  output logic [DATA_W-1:0] rdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= in_addr;
      wdata_q <= in_wdata;
      wr_q    <= in_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= pad_din;
    end
  end

endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
// Cycle sequencer: phase order and strobe decode.
module asram_seq
  import asram_pkg::*;
#(
  parameter int RD_CYC   = 1,
  parameter int WP_CYC   = 1,
  parameter int TURN_CYC = 1,
  parameter int CW       = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr_q,
  input  logic          cnt_done,
  output logic          cnt_load,
  output logic [CW-1:0] cnt_val,
  output logic          accept,
  output logic          capture,
  output logic          ack,
  output logic          sel,
  output logic          oe_act,
  output logic          we_act,
  output logic          drv
);

  localparam logic [CW-1:0] RD_LD   = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WP_LD   = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] TURN_LD = CW'(TURN_CYC - 1);

  asram_state_e state_q, state_d;
  logic         ack_d, ack_q;

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    ack_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          accept  = 1'b1;
          state_d = ST_SETUP;
        end
      end
      ST_SETUP: begin
        cnt_load = 1'b1;
        if (wr_q) begin
          cnt_val = WP_LD;
          state_d = ST_WRITE;
        end else begin
          cnt_val = RD_LD;
          state_d = ST_READ;
        end
      end
      ST_READ: begin
        if (cnt_done) begin
          capture  = 1'b1;
          ack_d    = 1'b1;
          cnt_load = 1'b1;
          cnt_val  = TURN_LD;
          state_d  = ST_TURN;
        end
      end
      ST_WRITE: begin
        if (cnt_done) begin
          state_d = ST_HOLD;
        end
      end
      ST_HOLD: begin
        ack_d   = 1'b1;
        state_d = ST_IDLE;
      end
      ST_TURN: begin
        if (cnt_done) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
    end
  end

  assign ack    = ack_q;
  assign sel    = (state_q == ST_SETUP) || (state_q == ST_READ) ||
                  (state_q == ST_WRITE) || (state_q == ST_HOLD);
  assign oe_act = (state_q == ST_READ);
  assign we_act = (state_q == ST_WRITE);
  assign drv    = (state_q == ST_WRITE) || (state_q == ST_HOLD);

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
// Top: clocked host port to asynchronous static RAM.
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 20,
  parameter int T_AA_NS = 20,
  parameter int T_WP_NS = 15,
  parameter int T_DW_NS = 10,
  parameter int T_HZ_NS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              ack,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int RD_CYC   = ns_to_cyc(T_AA_NS, CLK_NS);
  localparam int WP_CYC   = ns_to_cyc(imax(T_WP_NS, T_DW_NS), CLK_NS);
  localparam int TURN_CYC = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int MAX_CYC  = imax(imax(RD_CYC, WP_CYC), TURN_CYC);
  localparam int CW       = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  logic          cnt_load;
  logic [CW-1:0] cnt_val;
  logic          cnt_done;
  logic          accept;
  logic          capture;
  logic          wr_q;
  logic          sel;
  logic          oe_act;
  logic          we_act;
  logic          drv;

  asram_wait_cnt #(.CW(CW)) cnt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .done     (cnt_done)
  );

  asram_seq #(
    .RD_CYC   (RD_CYC),
    .WP_CYC   (WP_CYC),
    .TURN_CYC (TURN_CYC),
    .CW       (CW)
  ) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .wr_q     (wr_q),
    .cnt_done (cnt_done),
    .cnt_load (cnt_load),
    .cnt_val  (cnt_val),
    .accept   (accept),
    .capture  (capture),
    .ack      (ack),
    .sel      (sel),
    .oe_act   (oe_act),
    .we_act   (we_act),
    .drv      (drv)
  );

  asram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .capture  (capture),
    .in_addr  (req_addr),
    .in_wdata (req_wdata),
    .in_wr    (req_wr),
    .pad_din  (mem_dq_in),
    .addr_q   (mem_addr),
    .wdata_q  (mem_dq_out),
    .wr_q     (wr_q),
    .rdata_q  (rsp_rdata)
  );

  assign mem_ce_n  = !sel;
  assign mem_ce    = sel;
  assign mem_oe_n  = !oe_act;
  assign mem_we_n  = !we_act;
  assign mem_dq_oe = drv;

endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker, bound into every asram_ctrl instance.
module asram_ctrl_chk #(
  parameter int ADDR_W   = 17,
  parameter int TURN_CYC = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_ce,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe
);

  logic        chip_on;
  logic [15:0] oe_idle_q;

  assign chip_on = !mem_ce_n && mem_ce;

  // Cycles since the output enable was last low (saturating).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_idle_q <= '1;
    end else if (!mem_oe_n) begin
      oe_idle_q <= '0;
    end else if (oe_idle_q != '1) begin
      oe_idle_q <= oe_idle_q + 16'd1;
    end
  end

  assert_standby_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ce_n || !mem_ce) |-> (mem_oe_n && mem_we_n && !mem_dq_oe));

  assert_setup_before_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> ($past(chip_on) && mem_we_n));

  assert_ack_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  assert_we_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe && chip_on));

  assert_addr_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_on && $past(chip_on)) |-> $stable(mem_addr));

  assert_turn_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chip_on) |-> (int'(oe_idle_q) >= TURN_CYC));

  assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .TURN_CYC(TURN_CYC)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ack       (ack),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_ce    (mem_ce),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_ctrl_tb_top.sv
`timescale 1ns/1ps
module asram_ctrl_tb_top;

  localparam int CLK_NS = 20;
  localparam int E_RD   = (45 + CLK_NS - 1) / CLK_NS;  // 3
  localparam int E_WP   = (30 + CLK_NS - 1) / CLK_NS;  // 2
  localparam int E_TURN = (25 + CLK_NS - 1) / CLK_NS;  // 2

  logic        clk;
  logic        rst_n;
  logic        req;
  logic        req_wr;
  logic [16:0] req_addr;
  logic [7:0]  req_wdata;
  logic [7:0]  rsp_rdata;
  logic        ack;
  logic [16:0] mem_addr;
  logic        mem_ce_n;
  logic        mem_ce;
  logic        mem_oe_n;
  logic        mem_we_n;
  logic [7:0]  mem_dq_out;
  logic        mem_dq_oe;
  logic [7:0]  mem_dq_in;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;

  asram_ctrl #(
    .CLK_NS (CLK_NS), .T_AA_NS (45), .T_WP_NS (30), .T_DW_NS (20), .T_HZ_NS (25)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .req (req), .req_wr (req_wr),
    .req_addr (req_addr), .req_wdata (req_wdata), .rsp_rdata (rsp_rdata),
    .ack (ack), .mem_addr (mem_addr), .mem_ce_n (mem_ce_n), .mem_ce (mem_ce),
    .mem_oe_n (mem_oe_n), .mem_we_n (mem_we_n), .mem_dq_out (mem_dq_out),
    .mem_dq_oe (mem_dq_oe), .mem_dq_in (mem_dq_in)
  );

  initial clk = 1'b0;
  always #(CLK_NS / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] init_val(input logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ {7'b0, a[16]};
  endfunction

  // ---------------- RAM model ----------------
  logic [7:0] model_mem [logic [16:0]];
  logic [7:0] exp_mem   [logic [16:0]];
  logic       chip_on;
  assign chip_on = !mem_ce_n && mem_ce;

  always @* begin
    mem_dq_in = 8'hzz;
    if (chip_on && !mem_oe_n && mem_we_n) begin
      mem_dq_in = model_mem.exists(mem_addr) ? model_mem[mem_addr] : init_val(mem_addr);
    end
  end

  always @(posedge mem_we_n) begin
    if (rst_n && chip_on) begin
      chk(mem_dq_oe, "R4 data driven at strobe end", int'(mem_dq_oe), 1);
      model_mem[mem_addr] = mem_dq_out;
    end
  end

  // ---------------- port monitor ----------------
  int          we_run   = 0;
  int          oe_run   = 0;
  int          since_oe = 1000;
  int          last_gap = 0;
  logic        prev_on  = 1'b0;
  logic        prev_ack = 1'b0;
  logic [16:0] prev_addr;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_we_n) begin
        we_run++;
        if (!mem_oe_n) chk(0, "R4 oe low during write", 0, 1);
      end else if (we_run != 0) begin
        chk(we_run == E_WP, "R4 write strobe width", we_run, E_WP);
        we_run = 0;
      end
      if (!mem_oe_n) begin
        oe_run++;
        if (!mem_we_n) chk(0, "R2 we low during read", 0, 1);
      end else if (oe_run != 0) begin
        chk(oe_run == E_RD, "R2 output enable width", oe_run, E_RD);
        oe_run = 0;
      end
      if (mem_dq_oe && !mem_oe_n) chk(0, "R8 bus contention", 1, 0);
      if (chip_on && prev_on && mem_addr !== prev_addr)
        chk(0, "R5 address moved while selected", int'(mem_addr), int'(prev_addr));
      if (chip_on && !prev_on) begin
        last_gap = since_oe;
        chk(since_oe >= E_TURN + 1, "R7 deselect gap after read", since_oe, E_TURN + 1);
      end
      if (ack && prev_ack) chk(0, "R3 ack wider than one cycle", 1, 0);
      if (!mem_oe_n) since_oe = 0; else if (since_oe < 1000) since_oe++;
      prev_on   = chip_on;
      prev_ack  = ack;
      prev_addr = mem_addr;
    end
  end

  // ---------------- stimulus ----------------
  task automatic standby_check(input string tag);
    chk(mem_ce_n === 1'b1 && mem_ce === 1'b0, tag, int'({mem_ce_n, mem_ce}), 2);
    chk(mem_oe_n === 1'b1 && mem_we_n === 1'b1 && mem_dq_oe === 1'b0 && ack === 1'b0,
        tag, int'({mem_oe_n, mem_we_n, mem_dq_oe, ack}), 12);
  endtask

  task automatic idle_gap();
    repeat (E_TURN + 2) @(negedge clk);
    standby_check("R1 standby between transactions");
  endtask

  // Called at a falling edge; returns at the falling edge where ack is seen.
  task automatic do_txn(input bit wr, input logic [16:0] a, input logic [7:0] d,
                        input int exp_lat);
    int lat;
    logic [7:0] exp_rd;
    lat = 0;
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (lat == 1 && exp_lat > 0) begin
        req_addr = ~a; req_wdata = ~d; req_wr = ~wr;  // R9: changes after accept
      end
    end while (!ack && lat < 200);
    req = 1'b0;
    if (exp_lat > 0) begin
      if (wr) chk(lat == exp_lat, "R6 write ack latency", lat, exp_lat);
      else    chk(lat == exp_lat, "R3 read ack latency", lat, exp_lat);
    end
    if (wr) begin
      exp_mem[a] = d;
    end else begin
      exp_rd = exp_mem.exists(a) ? exp_mem[a] : init_val(a);
      chk(rsp_rdata === exp_rd, "R3 read data", int'(rsp_rdata), int'(exp_rd));
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      chk(0, "watchdog expired", cyc, 0);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd7731));
    rst_n = 1'b0; req = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    standby_check("R1 reset state");
    chk(rsp_rdata === 8'h00, "R1 read register reset", int'(rsp_rdata), 0);
    rst_n = 1'b1;
    idle_gap();

    // Directed corners: address extremes, unwritten location.
    do_txn(1'b1, 17'h00000, 8'h5A, E_WP + 3);     idle_gap();
    do_txn(1'b1, 17'h1FFFF, 8'hA5, E_WP + 3);     idle_gap();
    do_txn(1'b0, 17'h00000, 8'h00, E_RD + 2);     idle_gap();
    do_txn(1'b0, 17'h1FFFF, 8'h00, E_RD + 2);     idle_gap();
    do_txn(1'b0, 17'h0ABCD, 8'h00, E_RD + 2);     idle_gap();

    // R9: inputs scrambled after accept must not reach the RAM.
    do_txn(1'b1, 17'h00100, 8'h3C, E_WP + 3);     idle_gap();
    do_txn(1'b0, 17'h1FEFF, 8'h00, E_RD + 2);     idle_gap();
    do_txn(1'b0, 17'h00100, 8'h00, E_RD + 2);     idle_gap();

    // R7: back-to-back reads, exact deselect gap.
    do_txn(1'b0, 17'h00000, 8'h00, E_RD + 2);
    do_txn(1'b0, 17'h1FFFF, 8'h00, 0);
    chk(last_gap == E_TURN + 1, "R7 back-to-back read gap", last_gap, E_TURN + 1);
    // Read directly followed by write, and write followed by read.
    do_txn(1'b1, 17'h00001, 8'hC3, 0);
    do_txn(1'b0, 17'h00001, 8'h00, 0);
    idle_gap();

    // Constrained random mix over a small address pool.
    for (int i = 0; i < 80; i++) begin
      logic [16:0] a;
      logic        w;
      logic [7:0]  d;
      bit          gap;
      a   = 17'(($urandom % 16) * 32'h2223);
      w   = 1'($urandom % 2);
      d   = 8'($urandom);
      gap = ($urandom % 3) != 0;
      if (gap) begin
        idle_gap();
        do_txn(w, a, d, w ? E_WP + 3 : E_RD + 2);
      end else begin
        do_txn(w, a, d, 0);
      end
    end
    idle_gap();
    finish_run();
  end

endmodule